// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block watches the control strobes of an asynchronous DRAM interface from the device side. A fast clock samples them. It follows the row strobe, the column strobe, one write strobe per byte lane and the output enable. It works out which kind of access the controller is running, captures the row and column addresses at the right edges, and issues one-cycle write pulses for each byte lane. It also produces a per-lane enable for driving the read data bus. Because of this it can serve as a protocol monitor, or as the front end of a behavioural memory model that supplies the storage array.

All strobes are active low. The block finds edges by comparing each sample with the one before it. Every output is registered, so a decision made on the sample at one clock edge shows up just after that edge. A cycle opens when the row strobe falls. Each column strobe fall that comes while the row strobe stays low opens one column access. The write type of a column depends on the order of the strobes. A write strobe that is already low when the column strobe falls gives an early write. A write strobe that falls later gives a delayed write, or a read-modify-write if the output was driven first. When the row strobe rises, the block reports a 4-bit code that summarises the whole cycle.

Top module: `dram_cycle_decoder`

## Requirements
- R1: While reset is asserted and on the first sample after it, cyc_valid, cyc_code, col_stb, wr_stb, dq_oe and mix_err are all zero.
- R2: A row strobe fall sampled while the column strobe is high moves row_addr to the value on addr at that sample, and opens a row cycle.
- R3: A row cycle that closes with no column access reports code 5 (refresh of the latched row).
- R4: A row strobe fall sampled while the column strobe is low starts a refresh that reports code 6 when the row strobe rises. It leaves row_addr and col_addr unchanged, and it ignores the column and write strobes, which raise no col_stb and no wr_stb.
- R5: Each column strobe fall inside an open row pulses col_stb for one cycle and loads col_addr from the low COL_W bits of addr.
- R6: A column is an early write when any write strobe is low at its column strobe fall. Each lane that is low then gets a wr_stb pulse in that same cycle, and dq_oe stays zero for the whole column.
- R7: In a column that is not an early write, a write strobe fall while the column strobe is low pulses that lane's wr_stb. The column then counts as a read-modify-write (base code 4) if dq_oe was high on any earlier sample of the column, and as a delayed write (base code 3) otherwise.
- R8: The column's mode is chosen by all lanes together, but write pulses and output drive are kept per lane. A lane's wr_stb follows only its own strobe, and only that lane's dq_oe bit drops once it has been written.
- R9: dq_oe bit b is high, one cycle after the sample, for every sample where a non-early column is open, the column strobe and output enable are both low, and lane b has not been written in that column. It clears when the column strobe rises or the output enable goes high.
- R10: The cycle code is a base value chosen by priority across all columns of the cycle: read-modify-write 4, then delayed write 3, then early write 2, then read 1. Bit 3 is set when the row held two or more columns (page mode).
- R11: A write strobe that falls during an early-write column pulses mix_err for one cycle and writes nothing for that lane.
- R12: cyc_valid is high for exactly one cycle, on the sample where the row strobe rises, and cyc_code is zero whenever cyc_valid is low.
- R13: A write strobe fall that comes while the row strobe is high, or while the column strobe is high inside an open row, produces no wr_stb pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | NB | Per-lane write strobes, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed address bus |
| cyc_valid | output | 1 | One-cycle pulse when a cycle is reported |
| cyc_code | output | 4 | Cycle type code, zero when not valid |
| row_addr | output | ROW_W | Latched row address |
| col_addr | output | COL_W | Latched column address |
| col_stb | output | 1 | One-cycle pulse on each column capture |
| wr_stb | output | NB | Per-lane one-cycle write pulses |
| dq_oe | output | NB | Per-lane data output drive enable |
| mix_err | output | 1 | One-cycle pulse on mixed early/late writing |

## Verification
The bench builds the decoder with two byte lanes, a 6-bit row address and a 4-bit column address. With this configuration it can sweep every combination of no write, early write and late write on each lane, with the output enable both low and high, for single-column and two-column rows. That sweep covers every base code, the page bit, the drive-before-write split between read-modify-write and delayed write, and every mixed-lane error case. Directed sequences then cover the two refresh forms, strobes that must be ignored, and the output enable toggling during a read column.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_CBR  = 2'd2
  } cyc_state_e;

  typedef enum logic [2:0] {
    CK_NONE    = 3'd0,
    CK_READ    = 3'd1,
    CK_EARLY   = 3'd2,
    CK_DELAYED = 3'd3,
    CK_RMW     = 3'd4
  } col_kind_e;

  localparam logic [3:0] CODE_STANDBY = 4'd0;
  localparam logic [3:0] CODE_READ    = 4'd1;
  localparam logic [3:0] CODE_EARLY   = 4'd2;
  localparam logic [3:0] CODE_DELAYED = 4'd3;
  localparam logic [3:0] CODE_RMW     = 4'd4;
  localparam logic [3:0] CODE_ROW_REF = 4'd5;
  localparam logic [3:0] CODE_CBR_REF = 4'd6;
  localparam int         PAGE_BIT     = 3;

  // accumulator bit positions: 0 read, 1 early, 2 delayed, 3 rmw
  function automatic logic [3:0] kind_bit(col_kind_e k);
    case (k)
      CK_READ:    kind_bit = 4'b0001;
      CK_EARLY:   kind_bit = 4'b0010;
      CK_DELAYED: kind_bit = 4'b0100;
      CK_RMW:     kind_bit = 4'b1000;
      default:    kind_bit = 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] fold_code(logic [3:0] acc, logic page);
    logic [3:0] c;
    if (acc[3])      c = CODE_RMW;
    else if (acc[2]) c = CODE_DELAYED;
    else if (acc[1]) c = CODE_EARLY;
    else if (acc[0]) c = CODE_READ;
    else             c = CODE_ROW_REF;
    if (acc != 4'b0000 && page) c[PAGE_BIT] = 1'b1;
    fold_code = c;
  endfunction

endpackage

// File: rtl/dcd_edge.sv
module dcd_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_n,
  output logic [W-1:0] fall,
  output logic [W-1:0] rise
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= sig_n;
  end

  assign fall = prev_q & ~sig_n;
  assign rise = ~prev_q & sig_n;

endmodule

// File: rtl/dcd_lane.sv
module dcd_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic col_start,
  input  logic in_col,
  input  logic early_col,
  input  logic we_n,
  input  logic drive_ok,
  output logic late_wr,
  output logic wr_pulse,
  output logic mix_hit,
  output logic dq_oe
);

  logic we_prev_q, wrote_q, wr_q, mix_q, dq_q;
  logic we_fall, wrote_d, wr_d, mix_d, dq_d;

  assign we_fall = we_prev_q & ~we_n;

  always_comb begin
    wrote_d = wrote_q;
    wr_d    = 1'b0;
    mix_d   = 1'b0;
    late_wr = 1'b0;
    if (col_start) begin
      wrote_d = ~we_n;
      wr_d    = ~we_n;
    end else if (in_col && we_fall) begin
      if (early_col) begin
        mix_d = 1'b1;
      end else begin
        wr_d    = 1'b1;
        late_wr = 1'b1;
        wrote_d = 1'b1;
      end
    end
    dq_d = drive_ok & ~wrote_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev_q <= 1'b1;
      wrote_q   <= 1'b0;
      wr_q      <= 1'b0;
      mix_q     <= 1'b0;
      dq_q      <= 1'b0;
    end else begin
      we_prev_q <= we_n;
      wrote_q   <= wrote_d;
      wr_q      <= wr_d;
      mix_q     <= mix_d;
      dq_q      <= dq_d;
    end
  end

  assign wr_pulse = wr_q;
  assign mix_hit  = mix_q;
  assign dq_oe    = dq_q;

  p_wr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);

  p_mix_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mix_q |-> !dq_q);

endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder #(
  parameter int NB    = 2,
  parameter int ROW_W = 10,
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic [NB-1:0]    we_n,
  input  logic             oe_n,
  input  logic [ROW_W-1:0] addr,
  output logic             cyc_valid,
  output logic [3:0]       cyc_code,
  output logic [ROW_W-1:0] row_addr,
  output logic [COL_W-1:0] col_addr,
  output logic             col_stb,
  output logic [NB-1:0]    wr_stb,
  output logic [NB-1:0]    dq_oe,
  output logic             mix_err
);
  import dcd_pkg::*;

  localparam int         NCW      = 2;
  localparam logic [NCW-1:0] NCOL_MAX = '1;

  logic [1:0] fall, rise;
  logic ras_fall, cas_fall, ras_rise, cas_rise;

  dcd_edge #(.W(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sig_n({cas_n, ras_n}),
    .fall (fall),
    .rise (rise)
  );

  assign ras_fall = fall[0];
  assign cas_fall = fall[1];
  assign ras_rise = rise[0];
  assign cas_rise = rise[1];

  cyc_state_e      state_q, state_d;
  col_kind_e       kind_q, kind_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic            open_q, open_d;
  logic [3:0]      acc_q, acc_d;
  logic [NCW-1:0]  ncol_q, ncol_d;
  logic            seen_q, seen_d;
  logic            valid_q, valid_d;
  logic [3:0]      code_q, code_d;
  logic            stb_q, stb_d;

  logic col_start, in_col, open_next, early_next, drive_ok, any_we_low;
  logic [NB-1:0] late, wr_l, mix_l, dq_l;

  assign any_we_low = ~&we_n;
  assign col_start  = (state_q == ST_ROW) & cas_fall & ~ras_n;
  assign in_col     = (state_q == ST_ROW) & open_q & ~cas_n & ~ras_n;
  assign open_next  = (state_q == ST_ROW) & ~ras_rise &
                      (col_start | (open_q & ~cas_rise));
  assign early_next = col_start ? any_we_low : (kind_q == CK_EARLY);
  assign drive_ok   = open_next & ~early_next & ~oe_n & ~cas_n;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    dcd_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .col_start(col_start),
      .in_col   (in_col),
      .early_col(kind_q == CK_EARLY),
      .we_n     (we_n[b]),
      .drive_ok (drive_ok),
      .late_wr  (late[b]),
      .wr_pulse (wr_l[b]),
      .mix_hit  (mix_l[b]),
      .dq_oe    (dq_l[b])
    );
  end

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    row_d   = row_q;
    col_d   = col_q;
    open_d  = open_q;
    acc_d   = acc_q;
    ncol_d  = ncol_q;
    seen_d  = seen_q;
    valid_d = 1'b0;
    code_d  = CODE_STANDBY;
    stb_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ras_fall) begin
          if (!cas_n) begin
            state_d = ST_CBR;
          end else begin
            state_d = ST_ROW;
            row_d   = addr;
            acc_d   = '0;
            ncol_d  = '0;
            open_d  = 1'b0;
            kind_d  = CK_NONE;
          end
        end
      end
      ST_ROW: begin
        if (ras_rise) begin
          acc_d   = acc_q | (open_q ? kind_bit(kind_q) : 4'b0000);
          valid_d = 1'b1;
          code_d  = fold_code(acc_d, ncol_q >= NCW'(2));
          state_d = ST_IDLE;
          open_d  = 1'b0;
          kind_d  = CK_NONE;
        end else if (col_start) begin
          open_d = 1'b1;
          col_d  = addr[COL_W-1:0];
          stb_d  = 1'b1;
          if (ncol_q != NCOL_MAX) ncol_d = ncol_q + NCW'(1);
          kind_d = any_we_low ? CK_EARLY : CK_READ;
          seen_d = 1'b0;
        end else if (open_q) begin
          seen_d = seen_q | (|dq_l);
          if (cas_rise) begin
            acc_d  = acc_q | kind_bit(kind_q);
            open_d = 1'b0;
          end else if ((|late) && kind_q == CK_READ) begin
            kind_d = (seen_q | (|dq_l)) ? CK_RMW : CK_DELAYED;
          end
        end
      end
      ST_CBR: begin
        if (ras_rise) begin
          valid_d = 1'b1;
          code_d  = CODE_CBR_REF;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= CK_NONE;
      row_q   <= '0;
      col_q   <= '0;
      open_q  <= 1'b0;
      acc_q   <= '0;
      ncol_q  <= '0;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
      code_q  <= CODE_STANDBY;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      row_q   <= row_d;
      col_q   <= col_d;
      open_q  <= open_d;
      acc_q   <= acc_d;
      ncol_q  <= ncol_d;
      seen_q  <= seen_d;
      valid_q <= valid_d;
      code_q  <= code_d;
      stb_q   <= stb_d;
    end
  end

  assign cyc_valid = valid_q;
  assign cyc_code  = code_q;
  assign row_addr  = row_q;
  assign col_addr  = col_q;
  assign col_stb   = stb_q;
  assign wr_stb    = wr_l;
  assign dq_oe     = dq_l;
  assign mix_err   = |mix_l;

  p_valid_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> !cyc_valid);

  p_code_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |-> cyc_code == 4'd0);

  p_drive_needs_cas_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe) |-> !$past(cas_n));

  p_cbr_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CBR) |=> (wr_stb == '0 && !col_stb));

  p_early_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && kind_q == CK_EARLY) |-> dq_oe == '0);

endmodule

// File: tb/dram_cycle_decoder_tb.sv
`timescale 1ns/1ps
module dram_cycle_decoder_tb;
  localparam int NB = 2, ROW_W = 6, COL_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic ras_n, cas_n, oe_n;
  logic [NB-1:0] we_n;
  logic [ROW_W-1:0] addr;
  logic cyc_valid, col_stb, mix_err;
  logic [3:0] cyc_code;
  logic [ROW_W-1:0] row_addr;
  logic [COL_W-1:0] col_addr;
  logic [NB-1:0] wr_stb, dq_oe;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dram_cycle_decoder #(.NB(NB), .ROW_W(ROW_W), .COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .cyc_valid(cyc_valid), .cyc_code(cyc_code),
    .row_addr(row_addr), .col_addr(col_addr), .col_stb(col_stb),
    .wr_stb(wr_stb), .dq_oe(dq_oe), .mix_err(mix_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ceq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic drv(input logic r, input logic c, input logic [NB-1:0] w,
                     input logic o, input logic [ROW_W-1:0] a);
    @(negedge clk);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = '1; oe_n = 1'b1; addr = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    ceq("R1", "valid in reset", cyc_valid, 0);
    ceq("R1", "code in reset", cyc_code, 0);
    ceq("R1", "dq_oe in reset", dq_oe, 0);
    @(negedge clk); rst_n = 1'b1;
    drv(1, 1, 2'b11, 1, 0);
    ceq("R1", "wr after reset", wr_stb, 0);
    ceq("R1", "col_stb after reset", col_stb, 0);
    ceq("R1", "mix after reset", mix_err, 0);

    // R2 R3 row-only refresh
    drv(0, 1, 2'b11, 1, 6'd42);
    ceq("R2", "row latch", row_addr, 42);
    ceq("R12", "valid mid row", cyc_valid, 0);
    drv(0, 1, 2'b10, 1, 6'd7);
    ceq("R13", "we fall, cas high", wr_stb, 0);
    drv(0, 1, 2'b11, 1, 6'd7);
    drv(1, 1, 2'b11, 1, 6'd7);
    ceq("R3", "row refresh valid", cyc_valid, 1);
    ceq("R3", "row refresh code", cyc_code, 5);
    drv(1, 1, 2'b00, 1, 0);
    ceq("R13", "we fall, ras high", wr_stb, 0);
    ceq("R12", "valid drops", cyc_valid, 0);
    ceq("R12", "code zero idle", cyc_code, 0);
    drv(1, 1, 2'b11, 1, 0);

    // R4 column-before-row refresh
    drv(1, 0, 2'b11, 1, 6'd9);
    drv(0, 0, 2'b11, 1, 6'd9);
    ceq("R4", "row kept", row_addr, 42);
    drv(0, 0, 2'b00, 1, 6'd9);
    ceq("R4", "no write", wr_stb, 0);
    drv(0, 1, 2'b11, 1, 6'd9);
    drv(0, 0, 2'b11, 1, 6'd9);
    ceq("R4", "no col strobe", col_stb, 0);
    drv(1, 1, 2'b11, 1, 6'd9);
    ceq("R4", "cbr valid", cyc_valid, 1);
    ceq("R4", "cbr code", cyc_code, 6);
    ceq("R4", "row still kept", row_addr, 42);
    drv(1, 1, 2'b11, 1, 0);

    // R9 output enable toggling in a read column
    drv(0, 1, 2'b11, 1, 6'd3);
    drv(0, 0, 2'b11, 0, 6'd5);
    ceq("R5", "col latch", col_addr, 5);
    ceq("R5", "col strobe", col_stb, 1);
    ceq("R9", "drive on", dq_oe, 3);
    drv(0, 0, 2'b11, 1, 6'd5);
    ceq("R9", "oe high stops drive", dq_oe, 0);
    drv(0, 0, 2'b11, 0, 6'd5);
    ceq("R9", "oe low drives again", dq_oe, 3);
    ceq("R5", "col strobe single", col_stb, 0);
    drv(0, 1, 2'b11, 0, 6'd5);
    ceq("R9", "cas rise stops drive", dq_oe, 0);
    drv(1, 1, 2'b11, 1, 0);
    ceq("R10", "single read code", cyc_code, 1);

    // exhaustive lane-mode sweep
    for (int nc = 1; nc <= 2; nc++) begin
      for (int m0 = 0; m0 < 3; m0++) begin
        for (int m1 = 0; m1 < 3; m1++) begin
          for (int o = 0; o < 2; o++) begin
            logic [1:0] em, lm, ew, dq_exp;
            logic [ROW_W-1:0] ra;
            int base;
            em = {m1 == 1, m0 == 1};
            lm = {m1 == 2, m0 == 2};
            ra = ROW_W'(nc * 17 + m0 * 5 + m1 * 3 + o);
            drv(1, 1, 2'b11, 1, 0);
            drv(0, 1, 2'b11, 1, ra);
            ceq("R2", "sweep row", row_addr, int'(ra));
            for (int c = 0; c < nc; c++) begin
              logic [COL_W-1:0] ca;
              ca = COL_W'(m0 * 4 + m1 * 2 + c + o * 7);
              drv(0, 0, ~em, o[0], ROW_W'(ca));
              ceq("R5", "sweep col", col_addr, int'(ca));
              ceq("R6", "early pulses", wr_stb, em);
              dq_exp = (em == 0 && o == 0) ? 2'b11 : 2'b00;
              ceq("R9", "read drive", dq_oe, dq_exp);
              drv(0, 0, ~(em | lm), o[0], ROW_W'(ca));
              ew = (em != 0) ? 2'b00 : lm;
              ceq("R8", "late pulses per lane", wr_stb, ew);
              ceq("R11", "mix flag", mix_err, (em != 0 && lm != 0));
              dq_exp = (em == 0 && o == 0) ? (~lm & 2'b11) : 2'b00;
              ceq("R8", "per-lane drive release", dq_oe, dq_exp);
              drv(0, 1, 2'b11, 1, ROW_W'(ca));
              ceq("R7", "no pulse on close", wr_stb, 0);
              ceq("R9", "drive off on close", dq_oe, 0);
            end
            if (em != 0)      base = 2;
            else if (lm != 0) base = (o == 0) ? 4 : 3;
            else              base = 1;
            drv(1, 1, 2'b11, 1, 0);
            ceq("R12", "sweep valid", cyc_valid, 1);
            ceq("R10", "sweep code", cyc_code, base + ((nc > 1) ? 8 : 0));
            drv(1, 1, 2'b11, 1, 0);
            ceq("R12", "sweep valid single", cyc_valid, 0);
          end
        end
      end
    end

    // R10 priority across mixed page columns: read then early then delayed
    drv(0, 1, 2'b11, 1, 6'd1);
    drv(0, 0, 2'b11, 1, 6'd2);
    drv(0, 1, 2'b11, 1, 6'd2);
    drv(0, 0, 2'b10, 1, 6'd3);
    drv(0, 1, 2'b11, 1, 6'd3);
    drv(0, 0, 2'b11, 1, 6'd4);
    drv(0, 0, 2'b01, 1, 6'd4);
    ceq("R7", "delayed lane1 pulse", wr_stb, 2'b10);
    drv(0, 1, 2'b11, 1, 6'd4);
    drv(1, 1, 2'b11, 1, 0);
    ceq("R10", "priority code", cyc_code, 11);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule